// File: doc/BRIEF.md
# ECC Error Capture and Interrupt Unit

This unit sits beside a memory ECC decoder and records what the decoder reports. Every event from the decoder is tagged as correctable (CE) or uncorrectable (UE). Each class has its own capture set, holding a 34-bit failing address, 64 bits of data, an 8-bit syndrome and a 14-bit requester ID. The first event of a class is latched. Later events of that class, while the capture is still pending, only raise an overrun flag and leave the captured fields unchanged.

Software reaches the unit through a word-indexed 32-bit register port. Register reads are combinational. Writes take effect at the clock edge. Software enables checking, reads the status word, reads the captured fields, and releases status bits by writing ones to the acknowledge register. A single interrupt output is gated first by a per-bit ECC mask and then by a master mask. The master mask has a global disable bit and an ECC group bit.

Each class is controlled by a two-state machine. `CAP_ARMED` waits for an event. On an event of its class it takes the transition "capture" to `CAP_HELD` and loads the fields. `CAP_HELD` holds the fields. Writing a one to that class's capture-acknowledge bit takes the transition "release" back to `CAP_ARMED`. An event that arrives while the machine is in `CAP_HELD` is the "overrun" self-loop: the state does not change and the overrun flag is set.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, the following hold. The status word is 0. The enable register reads 0 and `ecc_on` is 0. The master mask reads 0xFFFFFFFF. The ECC mask reads 0x1FF. `irq` is 0.
- R2: Checking is on only while the enable register's bits [17:16] are both 1, and `ecc_on` shows this. While checking is off, events change neither status nor captured fields.
- R3: When `ev_valid` is 1 and checking is on, the event is routed by `ev_uncorr` (0 means CE, 1 means UE). If that class's capture bit is clear, its fields are latched at the clock edge and the capture bit is set. The CE capture bit is status bit 0 and the UE capture bit is status bit 2.
- R4: Each class has a set of capture registers. The low address register holds address bits 31:0. The high address register holds address bits 33:32 in bits [1:0] and the syndrome in bits [15:8]. The data low and data high registers hold data bits 31:0 and 63:32. The shared source register holds the CE ID in bits [29:16] and the UE ID in bits [13:0].
- R5: While a class's capture bit is set, a new event of that class leaves the captured fields unchanged and sets that class's overrun bit. The CE overrun bit is status bit 1 and the UE overrun bit is status bit 3.
- R6: An event of one class never changes the other class's status bits or captured fields.
- R7: Writing to the acknowledge register clears each status bit written with a one, and leaves bits written with a zero unchanged. The acknowledge register reads 0.
- R8: An event that arrives in the same cycle as the acknowledge of its class's capture bit is counted as an overrun and is not captured. If a set and a clear of an overrun bit arrive in the same cycle, the set wins.
- R9: `irq` is 1 exactly when all of the following hold: master mask bit 31 is clear, master mask bit 2 is clear, and some status bit n is set whose ECC mask bit n is clear.
- R10: Register readback works as follows. The enable register keeps only bits [17:16]. The master mask keeps all 32 bits. The ECC mask keeps bits [8:0]. Unmapped word indexes read 0.

Register word indexes are as follows:
- 0 enable
- 1 status
- 2 acknowledge
- 3 master mask
- 4 ECC mask
- 5 to 8: CE address low, address high/syndrome, data low, data high
- 9 to 12: UE address low, address high/syndrome, data low, data high
- 13 source

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ev_valid | input | 1 | Decoder event strobe |
| ev_uncorr | input | 1 | Event class: 0 means correctable, 1 means uncorrectable |
| ev_addr | input | 34 | Failing address |
| ev_data | input | 64 | Data word seen by the decoder |
| ev_synd | input | 8 | Syndrome |
| ev_src | input | 14 | Requester ID |
| ecc_on | output | 1 | Checking enabled |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the following corner cases:
- A second event of the same class while the first is still pending. A design that overwrote the capture would lose the first failing address.
- An event that coincides with the acknowledge of its capture. A design that captured it there would report fields that no handler ever saw.
- A partial enable value (01). A design that treated any nonzero enable as on would record events while checking is meant to be off.
- The global mask, the ECC group mask and the per-bit masks, each set on its own. A design that missed any one gate would assert an interrupt that should be silent.

Random sequences of events, acknowledges, mask changes and enable changes are compared against a bench model of both capture sets.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    typedef enum logic {
        CAP_ARMED = 1'b0,
        CAP_HELD  = 1'b1
    } cap_state_e;

    localparam int REG_AW    = 4;
    localparam int NUM_CLASS = 2;
    localparam int CLS_CE    = 0;
    localparam int CLS_UE    = 1;

    // word indexes of the register port
    localparam logic [REG_AW-1:0] IDX_ENABLE = 4'd0;
    localparam logic [REG_AW-1:0] IDX_STATUS = 4'd1;
    localparam logic [REG_AW-1:0] IDX_ACK    = 4'd2;
    localparam logic [REG_AW-1:0] IDX_MMASK  = 4'd3;
    localparam logic [REG_AW-1:0] IDX_EMASK  = 4'd4;
    localparam logic [REG_AW-1:0] IDX_CE_BASE = 4'd5;
    localparam logic [REG_AW-1:0] IDX_UE_BASE = 4'd9;
    localparam logic [REG_AW-1:0] IDX_SOURCE = 4'd13;

    // fixed bit positions
    localparam int EN_LSB       = 16;
    localparam int SYND_LSB     = 8;
    localparam int CE_SRC_LSB   = 16;
    localparam int UE_SRC_LSB   = 0;
    localparam int GMASK_BIT    = 31;
    localparam int GRP_MASK_BIT = 2;
    localparam int EMASK_W      = 9;

endpackage

// File: rtl/ecc_cap_class.sv
module ecc_cap_class
    import ecc_cap_pkg::*;
#(
    parameter int AW = 34,
    parameter int DW = 64,
    parameter int SW = 8,
    parameter int IW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_hit,
    input  logic [AW-1:0] ev_addr,
    input  logic [DW-1:0] ev_data,
    input  logic [SW-1:0] ev_synd,
    input  logic [IW-1:0] ev_src,
    input  logic          clr_cap,
    input  logic          clr_ovr,
    output logic          held,
    output logic          overrun,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data,
    output logic [SW-1:0] cap_synd,
    output logic [IW-1:0] cap_src
);

    cap_state_e state_q, state_d;
    logic       load;
    logic       ovr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            CAP_ARMED: if (ev_hit) begin
                state_d = CAP_HELD;
                load    = 1'b1;
            end
            CAP_HELD:  if (clr_cap) state_d = CAP_ARMED;
        endcase
    end

    always_comb begin
        held    = (state_q == CAP_HELD);
        overrun = ovr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q    <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
            cap_synd <= '0;
            cap_src  <= '0;
        end else begin
            ovr_q <= (held & ev_hit) | (ovr_q & ~clr_ovr);
            if (load) begin
                cap_addr <= ev_addr;
                cap_data <= ev_data;
                cap_synd <= ev_synd;
                cap_src  <= ev_src;
            end
        end
    end

    // R3
    arm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && ev_hit) |=> (held && cap_addr == $past(ev_addr) && cap_src == $past(ev_src)));

    // R5
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(cap_addr) && $stable(cap_data) && $stable(cap_synd) && $stable(cap_src)));

    // R5
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && ev_hit) |=> overrun);

endmodule

// File: rtl/ecc_cap_irq.sv
module ecc_cap_irq #(
    parameter int NSTAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSTAT-1:0] status,
    input  logic [NSTAT-1:0] bit_mask,
    input  logic             global_mask,
    input  logic             group_mask,
    output logic             irq
);

    logic [NSTAT-1:0] live;

    always_comb begin
        live = status & ~bit_mask;
        irq  = !global_mask && !group_mask && (live != '0);
    end

    // R9
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int AW = 34,
    parameter int DW = 64,
    parameter int SW = 8,
    parameter int IW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_valid,
    input  logic              ev_uncorr,
    input  logic [AW-1:0]     ev_addr,
    input  logic [DW-1:0]     ev_data,
    input  logic [SW-1:0]     ev_synd,
    input  logic [IW-1:0]     ev_src,
    output logic              ecc_on,
    output logic              irq
);

    localparam int NSTAT = 2 * NUM_CLASS;
    localparam int AHI_W = AW - 32;
    localparam int DHI_W = DW - 32;

    logic [1:0]          en_q;
    logic [31:0]         mmask_q;
    logic [EMASK_W-1:0]  emask_q;
    logic                ack_wr;
    logic [NSTAT-1:0]    clr_bits;
    logic [NSTAT-1:0]    status;
    logic [NUM_CLASS-1:0] hit;
    logic [NUM_CLASS-1:0] held, ovr;
    logic [AW-1:0]       c_addr [NUM_CLASS];
    logic [DW-1:0]       c_data [NUM_CLASS];
    logic [SW-1:0]       c_synd [NUM_CLASS];
    logic [IW-1:0]       c_src  [NUM_CLASS];

    always_comb begin
        ecc_on   = (en_q == 2'b11);
        ack_wr   = reg_wr && (reg_addr == IDX_ACK);
        clr_bits = ack_wr ? reg_wdata[NSTAT-1:0] : '0;
        hit[CLS_CE] = ev_valid && ecc_on && !ev_uncorr;
        hit[CLS_UE] = ev_valid && ecc_on && ev_uncorr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 2'b00;
            mmask_q <= '1;
            emask_q <= '1;
        end else if (reg_wr) begin
            if (reg_addr == IDX_ENABLE) en_q    <= reg_wdata[EN_LSB +: 2];
            if (reg_addr == IDX_MMASK)  mmask_q <= reg_wdata;
            if (reg_addr == IDX_EMASK)  emask_q <= reg_wdata[EMASK_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CLASS; g++) begin : g_cls
        ecc_cap_class #(.AW(AW), .DW(DW), .SW(SW), .IW(IW)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_hit   (hit[g]),
            .ev_addr  (ev_addr),
            .ev_data  (ev_data),
            .ev_synd  (ev_synd),
            .ev_src   (ev_src),
            .clr_cap  (clr_bits[2*g]),
            .clr_ovr  (clr_bits[2*g+1]),
            .held     (held[g]),
            .overrun  (ovr[g]),
            .cap_addr (c_addr[g]),
            .cap_data (c_data[g]),
            .cap_synd (c_synd[g]),
            .cap_src  (c_src[g])
        );
        assign status[2*g]   = held[g];
        assign status[2*g+1] = ovr[g];
    end

    ecc_cap_irq #(.NSTAT(NSTAT)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .status      (status),
        .bit_mask    (emask_q[NSTAT-1:0]),
        .global_mask (mmask_q[GMASK_BIT]),
        .group_mask  (mmask_q[GRP_MASK_BIT]),
        .irq         (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_ENABLE: reg_rdata[EN_LSB +: 2]  = en_q;
            IDX_STATUS: reg_rdata[NSTAT-1:0]    = status;
            IDX_MMASK:  reg_rdata               = mmask_q;
            IDX_EMASK:  reg_rdata[EMASK_W-1:0]  = emask_q;
            IDX_SOURCE: begin
                reg_rdata[CE_SRC_LSB +: IW] = c_src[CLS_CE];
                reg_rdata[UE_SRC_LSB +: IW] = c_src[CLS_UE];
            end
            IDX_CE_BASE:        reg_rdata = c_addr[CLS_CE][31:0];
            IDX_CE_BASE + 4'd1: begin
                reg_rdata[AHI_W-1:0]      = c_addr[CLS_CE][AW-1:32];
                reg_rdata[SYND_LSB +: SW] = c_synd[CLS_CE];
            end
            IDX_CE_BASE + 4'd2: reg_rdata = c_data[CLS_CE][31:0];
            IDX_CE_BASE + 4'd3: reg_rdata[DHI_W-1:0] = c_data[CLS_CE][DW-1:32];
            IDX_UE_BASE:        reg_rdata = c_addr[CLS_UE][31:0];
            IDX_UE_BASE + 4'd1: begin
                reg_rdata[AHI_W-1:0]      = c_addr[CLS_UE][AW-1:32];
                reg_rdata[SYND_LSB +: SW] = c_synd[CLS_UE];
            end
            IDX_UE_BASE + 4'd2: reg_rdata = c_data[CLS_UE][31:0];
            IDX_UE_BASE + 4'd3: reg_rdata[DHI_W-1:0] = c_data[CLS_UE][DW-1:32];
            default:            reg_rdata = '0;
        endcase
    end

    // R2
    off_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_on && !ack_wr) |=> $stable(status));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && reg_wdata[0] && status[0]) |=> !status[0]);

    // R9
    global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmask_q[GMASK_BIT] |-> !irq);

endmodule

// File: tb/ecc_err_capture_tb.sv
module ecc_err_capture_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_valid = 1'b0;
    logic        ev_uncorr = 1'b0;
    logic [33:0] ev_addr = '0;
    logic [63:0] ev_data = '0;
    logic [7:0]  ev_synd = '0;
    logic [13:0] ev_src = '0;
    logic        ecc_on;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // bench model
    logic        m_held [2];
    logic        m_ovr  [2];
    logic [33:0] m_addr [2];
    logic [63:0] m_data [2];
    logic [7:0]  m_synd [2];
    logic [13:0] m_src  [2];
    logic [1:0]  m_en;
    logic [31:0] m_mmask;
    logic [8:0]  m_emask;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_capture u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
        .ev_uncorr(ev_uncorr), .ev_addr(ev_addr), .ev_data(ev_data),
        .ev_synd(ev_synd), .ev_src(ev_src), .ecc_on(ecc_on), .irq(irq)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_status();
        return {m_ovr[1], m_held[1], m_ovr[0], m_held[0]};
    endfunction

    function automatic logic exp_irq();
        return !m_mmask[31] && !m_mmask[2] && ((exp_status() & ~m_emask[3:0]) != 4'h0);
    endfunction

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        reg_addr = idx;
        #1;
        val = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
        if (idx == 4'd0) m_en = val[17:16];
        if (idx == 4'd3) m_mmask = val;
        if (idx == 4'd4) m_emask = val[8:0];
        if (idx == 4'd2) begin
            for (int c = 0; c < 2; c++) begin
                if (val[2*c])   m_held[c] = 1'b0;
                if (val[2*c+1]) m_ovr[c]  = 1'b0;
            end
        end
    endtask

    task automatic model_event(int c, logic [33:0] a, logic [63:0] d, logic [7:0] s, logic [13:0] i);
        if (m_en != 2'b11) return;
        if (!m_held[c]) begin
            m_held[c] = 1'b1; m_addr[c] = a; m_data[c] = d; m_synd[c] = s; m_src[c] = i;
        end else begin
            m_ovr[c] = 1'b1;
        end
    endtask

    task automatic drive_ev(int c, logic [33:0] a, logic [63:0] d, logic [7:0] s, logic [13:0] i,
                            logic with_ack, logic [3:0] ack_bits);
        @(negedge clk);
        ev_valid = 1'b1; ev_uncorr = (c == 1); ev_addr = a; ev_data = d; ev_synd = s; ev_src = i;
        if (with_ack) begin reg_wr = 1'b1; reg_addr = 4'd2; reg_wdata = {28'h0, ack_bits}; end
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
        model_event(c, a, d, s, i);
        if (with_ack) begin
            if (ack_bits[2*c]) m_held[c] = 1'b0;
        end
    endtask

    task automatic rand_ev(int c);
        drive_ev(c, {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom), 14'($urandom), 1'b0, 4'h0);
    endtask

    task automatic check_state(string tag);
        logic [31:0] v;
        rd(4'd1, v);
        check({tag, " status"}, 64'(v), 64'(exp_status()));
        check({tag, " irq"}, 64'(irq), 64'(exp_irq()));
    endtask

    task automatic check_caps(string tag);
        logic [31:0] v;
        for (int c = 0; c < 2; c++) begin
            logic [3:0] b;
            b = (c == 0) ? 4'd5 : 4'd9;
            rd(b, v);        check({tag, " addr_lo"}, 64'(v), 64'(m_addr[c][31:0]));
            rd(b + 4'd1, v); check({tag, " addr_hi/synd"}, 64'(v),
                                   64'({16'h0, m_synd[c], 6'h0, m_addr[c][33:32]}));
            rd(b + 4'd2, v); check({tag, " data_lo"}, 64'(v), 64'(m_data[c][31:0]));
            rd(b + 4'd3, v); check({tag, " data_hi"}, 64'(v), 64'(m_data[c][63:32]));
        end
        rd(4'd13, v);
        check({tag, " source"}, 64'(v), 64'({2'b0, m_src[0], 2'b0, m_src[1]}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_held[c] = 0; m_ovr[c] = 0; m_addr[c] = 0; m_data[c] = 0; m_synd[c] = 0; m_src[c] = 0;
        end
        m_en = 2'b00; m_mmask = 32'hFFFF_FFFF; m_emask = 9'h1FF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check_state("R1");
        rd(4'd0, v); check("R1 enable", 64'(v), 64'h0);
        rd(4'd3, v); check("R1 master mask", 64'(v), 64'hFFFF_FFFF);
        rd(4'd4, v); check("R1 ecc mask", 64'(v), 64'h1FF);
        check("R1 ecc_on", 64'(ecc_on), 64'h0);

        // R2 events ignored while off, and with a partial enable
        rand_ev(0); rand_ev(1);
        check_state("R2 off");
        wr(4'd0, 32'h0001_0000);
        check("R2 partial ecc_on", 64'(ecc_on), 64'h0);
        rand_ev(0);
        check_state("R2 partial");
        check_caps("R2");

        // R10 readback
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); check("R10 enable readback", 64'(v), 64'h0003_0000);
        check("R2 ecc_on", 64'(ecc_on), 64'h1);
        wr(4'd3, 32'h7FFF_FFFB);
        rd(4'd3, v); check("R10 master readback", 64'(v), 64'h7FFF_FFFB);
        wr(4'd4, 32'hFFFF_FFF0);
        rd(4'd4, v); check("R10 ecc mask readback", 64'(v), 64'h1F0);
        rd(4'd14, v); check("R10 unmapped", 64'(v), 64'h0);

        // R3 R4 CE capture, R6 UE independent, R5 overrun
        drive_ev(0, 34'h2_DEAD_BEEF, 64'h0123_4567_89AB_CDEF, 8'hA5, 14'h1ABC, 1'b0, 4'h0);
        check_state("R3 CE");
        check_caps("R4 CE");
        drive_ev(1, 34'h1_1234_5678, 64'hFEDC_BA98_7654_3210, 8'h03, 14'h0777, 1'b0, 4'h0);
        check_state("R6 UE");
        check_caps("R6");
        rand_ev(0);
        check_state("R5 CE overrun");
        check_caps("R5");

        // R7 acknowledge
        rd(4'd2, v); check("R7 ack reads 0", 64'(v), 64'h0);
        wr(4'd2, 32'h2);
        check_state("R7 clear ovr");
        wr(4'd2, 32'h1);
        check_state("R7 clear cap");

        // R9 mask gating (UE capture still pending)
        wr(4'd4, 32'h1F4); check_state("R9 bit mask");
        wr(4'd4, 32'h1F0); check_state("R9 unmasked");
        wr(4'd3, 32'hFFFF_FFFB); check_state("R9 global");
        wr(4'd3, 32'h7FFF_FFFF); check_state("R9 group");
        wr(4'd3, 32'h7FFF_FFFB);

        // R8 event coincident with acknowledge of its capture
        drive_ev(1, 34'h3_0000_0001, 64'h1, 8'h11, 14'h0001, 1'b1, 4'h4);
        check_state("R8 coincident");
        check_caps("R8");

        // random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0, 1, 2: rand_ev(int'($urandom % 2));
                3: wr(4'd2, 32'($urandom % 16));
                4: wr(4'd4, 32'($urandom));
                default: wr(4'd0, ($urandom % 4 != 0) ? 32'h0003_0000 : 32'($urandom));
            endcase
            check_state("R3 R5 R7 R9 random");
            if (k % 8 == 7) check_caps("R4 R6 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule